// File: doc/BRIEF.md
# Sync-Preset Clock State Generator

This block keeps the internal clock state of several identical devices in step with one shared, periodic sync input. The sync input is brought into the SYSCLK domain through a short flop chain, and its rising edge is turned into a single-cycle sync pulse. That pulse loads a per-device preset word into a free-running state counter, which then keeps stepping from that value.

Devices that see aligned sync edges and share a preset word hold identical states. Devices given presets that differ by k hold a constant state offset of k modulo 2^STATE_W. A registered phase-zero flag is provided as an example derived clock enable.

A sticky sampling-error flag catches a sync input that did not stay high long enough to be sampled reliably. This check can be switched off and is cleared by a pulse on a clear input.

Top module: `sps_clock_state_gen`

## Requirements
- R1: While reset is asserted, and at the first check after reset, state_o is 0, sync_pulse_o is 0, phase_zero_o is 1 and sample_err_o is 0.
- R2: With rx_enable high, if sync_in is sampled 0 at one SYSCLK rising edge and 1 at the next edge n, sync_pulse_o is high for exactly the cycle between edges n+1 and n+2.
- R3: sync_pulse_o is never high for two cycles in a row, and a sync_in held high for several cycles produces only one pulse.
- R4: In the cycle after a sync pulse, state_o equals the preset_word value sampled at the edge that ends the pulse cycle.
- R5: In all other cycles, state_o increments by one per SYSCLK and wraps from 63 to 0. A load that falls on the cycle where the counter would wrap takes priority over the wrap.
- R6: With rx_enable low, a rising sync_in edge produces no pulse and the counter keeps free-running.
- R7: phase_zero_o is high in exactly those cycles in which state_o is 0.
- R8: With chk_off low, a pulse whose sync_in is sampled 1 at edge n and 0 at edge n+1 sets sample_err_o after edge n+2. The flag then stays set until it is cleared.
- R9: A one-cycle pulse on err_clear clears sample_err_o at the next edge. A new error in that same cycle wins over the clear. With chk_off high, sample_err_o is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | SYSCLK |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_in | input | 1 | Periodic sync input, asynchronous to clk |
| rx_enable | input | 1 | Enables sync pulse generation |
| chk_off | input | 1 | Disables the sampling-error check |
| err_clear | input | 1 | Clears the sticky sampling-error flag |
| preset_word | input | STATE_W | State loaded by a sync pulse |
| state_o | output | STATE_W | Current clock state |
| sync_pulse_o | output | 1 | One-cycle sync pulse |
| phase_zero_o | output | 1 | High while state_o is 0 |
| sample_err_o | output | 1 | Sticky sampling-error flag |

## Verification
Two pairs of events can fall in the same cycle. A preset load can land on the edge where the counter would wrap from 63 to 0. An error set can coincide with an err_clear pulse. The bench waits until the free-running count puts 63 on the edge before the load and then raises sync_in; it expects the preset value, not 0, and a low phase_zero_o. For the second pair it drives a one-sample sync high with err_clear timed onto the setting edge, and judges the flag as set.

// File: rtl/sps_pkg.sv
package sps_pkg;
    localparam int unsigned SPS_STATE_W     = 6;
    localparam int unsigned SPS_SYNC_STAGES = 2;

    // Edge detector result handed to the counter and the sample checker
    typedef struct packed {
        logic pulse;       // one-cycle sync pulse
        logic next_level;  // newer synchronizer sample, one cycle ahead
    } sps_edge_t;
endpackage

// File: rtl/sps_sync_edge.sv
module sps_sync_edge #(
    parameter int unsigned STAGES = sps_pkg::SPS_SYNC_STAGES  // must be at least 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_raw,
    input  logic              rx_enable,
    output sps_pkg::sps_edge_t edge_o
);
    localparam int unsigned CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], sync_raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic synced_lvl, history_lvl;
    assign synced_lvl  = st_q.chain[STAGES-1];
    assign history_lvl = st_q.chain[STAGES];

    assign edge_o.pulse      = rx_enable & synced_lvl & ~history_lvl;
    assign edge_o.next_level = st_q.chain[STAGES-2];

    // R3: a pulse never lasts more than one cycle
    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o.pulse |=> !edge_o.pulse);
endmodule

// File: rtl/sps_state_counter.sv
module sps_state_counter #(
    parameter int unsigned STATE_W = sps_pkg::SPS_STATE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [STATE_W-1:0] preset,
    output logic [STATE_W-1:0] state_o,
    output logic               zero_o
);
    typedef struct packed {
        logic [STATE_W-1:0] cnt;
        logic               zero;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = preset;
        end else begin
            st_d.cnt = STATE_W'(st_q.cnt + 1'b1);
        end
        st_d.zero = (st_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.zero <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q.cnt;
    assign zero_o  = st_q.zero;

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> state_o == $past(preset));

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> state_o == STATE_W'($past(state_o) + 1'b1));

    assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o == (state_o == '0));
endmodule

// File: rtl/sps_sample_check.sv
module sps_sample_check (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    input  logic next_level,
    input  logic chk_off,
    input  logic err_clear,
    output logic err_o
);
    typedef struct packed {
        logic err;
    } chk_st_t;

    chk_st_t st_d, st_q;
    logic    bad_sample;

    // a pulse whose following sample has already dropped was caught unreliably
    assign bad_sample = pulse & ~next_level & ~chk_off;

    always_comb begin
        st_d = st_q;
        if (err_clear) begin
            st_d.err = 1'b0;
        end
        if (bad_sample) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o = st_q.err;

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o && !err_clear |=> err_o);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_clear && !pulse |=> !err_o);
endmodule

// File: rtl/sps_clock_state_gen.sv
module sps_clock_state_gen #(
    parameter int unsigned STATE_W     = sps_pkg::SPS_STATE_W,
    parameter int unsigned SYNC_STAGES = sps_pkg::SPS_SYNC_STAGES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_in,
    input  logic               rx_enable,
    input  logic               chk_off,
    input  logic               err_clear,
    input  logic [STATE_W-1:0] preset_word,
    output logic [STATE_W-1:0] state_o,
    output logic               sync_pulse_o,
    output logic               phase_zero_o,
    output logic               sample_err_o
);
    sps_pkg::sps_edge_t edge_info;

    sps_sync_edge #(.STAGES(SYNC_STAGES)) i_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_raw  (sync_in),
        .rx_enable (rx_enable),
        .edge_o    (edge_info)
    );

    sps_state_counter #(.STATE_W(STATE_W)) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (edge_info.pulse),
        .preset  (preset_word),
        .state_o (state_o),
        .zero_o  (phase_zero_o)
    );

    sps_sample_check i_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse      (edge_info.pulse),
        .next_level (edge_info.next_level),
        .chk_off    (chk_off),
        .err_clear  (err_clear),
        .err_o      (sample_err_o)
    );

    assign sync_pulse_o = edge_info.pulse;
endmodule

// File: tb/test_sps_clock_state_gen.sv
module test_sps_clock_state_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_in = 1'b0;
    logic       rx_enable = 1'b1;
    logic       chk_off = 1'b0;
    logic       err_clear = 1'b0;
    logic [5:0] preset_word = '0;
    logic [5:0] state_o;
    logic       sync_pulse_o, phase_zero_o, sample_err_o;

    always #4 clk = ~clk;  // 125 MHz

    sps_clock_state_gen i_sps_clock_state_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_in      (sync_in),
        .rx_enable    (rx_enable),
        .chk_off      (chk_off),
        .err_clear    (err_clear),
        .preset_word  (preset_word),
        .state_o      (state_o),
        .sync_pulse_o (sync_pulse_o),
        .phase_zero_o (phase_zero_o),
        .sample_err_o (sample_err_o)
    );

    // kinds: 0 state, 1 pulse, 2 phase zero, 3 sample error
    typedef struct {
        int    due;
        int    kind;
        int    val;
        string tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    int  cyc = 0;
    int  total = 0;
    int  fails = 0;
    bit  done = 0;
    int  base_cyc = 0;
    int  base_val = 0;
    int  exp_err = 0;

    function automatic void push(int due, int kind, int val, string tag);
        exp_item_t it;
        it.due = due; it.kind = kind; it.val = val; it.tag = tag;
        exp_q.push_back(it);
    endfunction

    function automatic int exp_state(int t);
        return (base_val + t - base_cyc) & 63;
    endfunction

    // monitor: compare every item due in the cycle just completed
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            for (int i = exp_q.size() - 1; i >= 0; i--) begin
                if (exp_q[i].due <= cyc) begin
                    int act;
                    case (exp_q[i].kind)
                        0: act = int'(state_o);
                        1: act = int'(sync_pulse_o);
                        2: act = int'(phase_zero_o);
                        default: act = int'(sample_err_o);
                    endcase
                    total++;
                    if (act != exp_q[i].val) begin
                        fails++;
                        $display("FAIL %s kind=%0d cycle=%0d actual=%0d expected=%0d",
                                 exp_q[i].tag, exp_q[i].kind, cyc, act, exp_q[i].val);
                    end
                    exp_q.delete(i);
                end
            end
        end
    end

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            push(cyc + 1, 0, exp_state(cyc + 1), "R5");
            push(cyc + 1, 2, (exp_state(cyc + 1) == 0) ? 1 : 0, "R7");
            push(cyc + 1, 3, exp_err, "R8");
        end
    endtask

    task automatic sync_event(int preset, int width, bit enabled, int new_err,
                              bit clr_same, string tag);
        int c;
        @(negedge clk);
        c = cyc;
        preset_word = 6'(preset);
        sync_in = 1'b1;
        push(c + 1, 1, 0, "R2");
        push(c + 1, 0, exp_state(c + 1), "R5");
        push(c + 2, 1, enabled ? 1 : 0, enabled ? "R2" : "R6");
        push(c + 2, 0, exp_state(c + 2), "R5");
        push(c + 3, 1, 0, "R3");
        push(c + 4, 1, 0, "R3");
        push(c + 5, 1, 0, "R3");
        if (enabled) begin
            base_cyc = c + 3;
            base_val = preset;
        end
        push(c + 3, 0, exp_state(c + 3), enabled ? tag : "R6");
        push(c + 4, 0, exp_state(c + 4), enabled ? "R4" : "R6");
        push(c + 3, 2, (exp_state(c + 3) == 0) ? 1 : 0, "R7");
        push(c + 4, 3, new_err, clr_same ? "R9" : "R8");
        exp_err = new_err;
        while (cyc < c + 6) begin
            @(negedge clk);
            if (cyc == c + width) sync_in = 1'b0;
            err_clear = (clr_same && cyc == c + 2) ? 1'b1 : 1'b0;
        end
        err_clear = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clear = 1'b1;
        exp_err = 0;
        push(cyc + 1, 3, 0, "R9");
        @(negedge clk);
        err_clear = 1'b0;
    endtask

    // driver
    initial begin
        repeat (3) @(negedge clk);
        push(cyc + 1, 0, 0, "R1");
        push(cyc + 1, 1, 0, "R1");
        push(cyc + 1, 2, 1, "R1");
        push(cyc + 1, 3, 0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        base_cyc = cyc;
        base_val = 0;
        idle(70);                                  // free run with wrap, R5 and R7
        sync_event(12, 3, 1'b1, 0, 1'b0, "R4");    // load of preset 12
        idle(10);
        sync_event(40, 5, 1'b1, 0, 1'b0, "R4");    // long high: single pulse, R3
        idle(10);
        while (exp_state(cyc + 3) != 63) @(negedge clk);
        sync_event(5, 3, 1'b1, 0, 1'b0, "R5");     // load on the wrap cycle
        idle(8);
        rx_enable = 1'b0;
        sync_event(20, 3, 1'b0, 0, 1'b0, "R6");    // gated receiver
        idle(8);
        rx_enable = 1'b1;
        sync_event(7, 1, 1'b1, 1, 1'b0, "R4");     // one-sample high sets error, R8
        idle(6);
        clear_err();
        idle(4);
        chk_off = 1'b1;
        sync_event(9, 1, 1'b1, 0, 1'b0, "R4");     // check disabled, R9
        idle(4);
        chk_off = 1'b0;
        sync_event(33, 1, 1'b1, 1, 1'b1, "R4");    // set wins over clear, R9
        idle(4);
        clear_err();
        idle(5);
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule